// File: doc/BRIEF.md
# CAN Identifier Acceptance Filter

This block decides which received CAN frames reach the host. Every completed frame is first written into a background holding buffer. The block then compares the frame's four identifier bytes, one bit at a time, with four programmable acceptance bytes. Four mask bytes mark some of those bits as don't-care.

A frame that matches is copied into a foreground buffer and raises a receive-full flag for the host. A frame that does not match stays in the background buffer, raises no flag, and is overwritten by the next frame. The frame's IDE flag sets how many bytes take part in the match: all four for an extended identifier, and only the first two for a standard identifier.

The acceptance and mask bytes can always be read. They can be written only while the initialization-mode request and its acknowledge are both high. The host clears the flags by pulsing write-one-to-clear inputs.

Top module: `can_id_filter`

## Requirements
- R1: When `frm_done` is high at a rising edge, `bg_id` and `bg_ide` hold `frm_id` and `frm_ide` from the next cycle on, whatever the identifier.
- R2: Per identifier bit, a mask bit of 1 makes the bit don't-care, and a mask bit of 0 requires the received bit to equal the acceptance bit. The decision is taken at the edge after the capture edge. An accepted frame appears on `rx_id`/`rx_ide` with `rx_full` high in that same cycle.
- R3: When `frm_ide`=1, identifier bytes 0 to 3 are all compared. Byte k is `frm_id[8k+7:8k]`. It is checked against acceptance register k (address k) and mask register k (address 4+k).
- R4: When `frm_ide`=0, only bytes 0 and 1 are compared. Bytes 2 and 3 have no effect on the decision.
- R5: A rejected frame leaves `rx_id`, `rx_ide`, `rx_full` and `rx_ovr` unchanged. The next frame overwrites it in the background buffer.
- R6: A write with `cfg_we`=1 updates the register at `cfg_addr` only when `init_req` and `init_ack` are both 1. Otherwise the register keeps its value.
- R7: `cfg_rdata` shows the register at `cfg_addr` in the same cycle, in every mode. Addresses 0 to 3 are acceptance bytes 0 to 3. Addresses 4 to 7 are mask bytes 0 to 3.
- R8: After reset, all eight registers read 0, and the buffers and both flags are 0.
- R9: An accepted frame that arrives while `rx_full` stays set leaves the foreground buffer unchanged and sets `rx_ovr`.
- R10: A 1 on `rx_clr_full` clears `rx_full` at the next edge. A clear in the decision cycle lets that cycle's accepted frame load without an overrun.
- R11: A 1 on `rx_clr_ovr` clears `rx_ovr`. A new overrun in the same cycle takes priority and keeps it set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| init_req | input | 1 | Initialization mode requested |
| init_ack | input | 1 | Initialization mode acknowledged |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 3 | Register address (0-3 acceptance, 4-7 mask) |
| cfg_wdata | input | 8 | Register write data |
| cfg_rdata | output | 8 | Register read data |
| frm_done | input | 1 | Frame complete strobe |
| frm_id | input | 32 | Identifier bytes, byte k at [8k+7:8k] |
| frm_ide | input | 1 | 1 = extended identifier, 0 = standard |
| bg_id | output | 32 | Background buffer identifier |
| bg_ide | output | 1 | Background buffer IDE flag |
| rx_id | output | 32 | Foreground buffer identifier |
| rx_ide | output | 1 | Foreground buffer IDE flag |
| rx_full | output | 1 | Receive-full flag |
| rx_ovr | output | 1 | Overrun flag |
| rx_clr_full | input | 1 | Write 1 to clear `rx_full` |
| rx_clr_ovr | input | 1 | Write 1 to clear `rx_ovr` |

## Verification
The filter is tried with five kinds of frame:
- an exact match;
- a frame that differs only in a masked bit;
- a frame that differs in an unmasked bit of byte 3, sent once as extended and once as standard;
- standard frames that differ in byte 0 or byte 1;
- matching frames sent while the receive-full flag is still set.

The exact match and the masked-bit frame separate correct mask polarity from an inverted one. The byte-3 pair shows whether the IDE flag really narrows the compare to two bytes. The byte-0 and byte-1 frames show that narrowing does not drop any bytes that must be checked. The frames sent while the flag is set, with and without a clear in the same cycle, separate overrun from overwrite.

// File: rtl/can_filt_pkg.sv
package can_filt_pkg;
  localparam int BYTE_W    = 8;
  localparam int NUM_BYTES = 4;
  localparam int STD_BYTES = 2;

  // One byte passes when every bit either matches or is masked out
  function automatic logic byte_hit(input logic [BYTE_W-1:0] rx,
                                    input logic [BYTE_W-1:0] acc,
                                    input logic [BYTE_W-1:0] msk);
    return &((~(rx ^ acc)) | msk);
  endfunction

  // Byte k takes part in the match for this identifier format
  function automatic logic byte_used(input int k, input logic ide, input int std_n);
    return ide || (k < std_n);
  endfunction
endpackage

// File: rtl/can_filt_regs.sv
module can_filt_regs #(
  parameter int BYTE_W    = can_filt_pkg::BYTE_W,
  parameter int NUM_BYTES = can_filt_pkg::NUM_BYTES,
  localparam int AW       = $clog2(2 * NUM_BYTES)
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        wr_ok,
  input  logic [AW-1:0]               addr,
  input  logic [BYTE_W-1:0]           wdata,
  output logic [BYTE_W-1:0]           rdata,
  output logic [NUM_BYTES*BYTE_W-1:0] acc_flat,
  output logic [NUM_BYTES*BYTE_W-1:0] msk_flat
);
  logic [AW-2:0] idx;
  logic          sel_msk;
  logic [BYTE_W-1:0] acc_q [NUM_BYTES];
  logic [BYTE_W-1:0] msk_q [NUM_BYTES];

  assign idx     = addr[AW-2:0];
  assign sel_msk = addr[AW-1];

  for (genvar k = 0; k < NUM_BYTES; k++) begin : g_byte
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        acc_q[k] <= '0;
        msk_q[k] <= '0;
      end else if (wr_ok && (int'(idx) == k)) begin
        if (sel_msk) msk_q[k] <= wdata;
        else         acc_q[k] <= wdata;
      end
    end
    assign acc_flat[k*BYTE_W +: BYTE_W] = acc_q[k];
    assign msk_flat[k*BYTE_W +: BYTE_W] = msk_q[k];
  end

  always_comb rdata = sel_msk ? msk_q[idx] : acc_q[idx];
endmodule

// File: rtl/can_filt_match.sv
module can_filt_match #(
  parameter int BYTE_W    = can_filt_pkg::BYTE_W,
  parameter int NUM_BYTES = can_filt_pkg::NUM_BYTES,
  parameter int STD_BYTES = can_filt_pkg::STD_BYTES
) (
  input  logic [NUM_BYTES*BYTE_W-1:0] id_flat,
  input  logic                        ide,
  input  logic [NUM_BYTES*BYTE_W-1:0] acc_flat,
  input  logic [NUM_BYTES*BYTE_W-1:0] msk_flat,
  output logic                        hit
);
  logic [NUM_BYTES-1:0] byte_ok;

  for (genvar k = 0; k < NUM_BYTES; k++) begin : g_cmp
    assign byte_ok[k] = !can_filt_pkg::byte_used(k, ide, STD_BYTES) ||
                        can_filt_pkg::byte_hit(id_flat[k*BYTE_W +: BYTE_W],
                                               acc_flat[k*BYTE_W +: BYTE_W],
                                               msk_flat[k*BYTE_W +: BYTE_W]);
  end

  assign hit = &byte_ok;
endmodule

// File: rtl/can_filt_rxbuf.sv
module can_filt_rxbuf #(
  parameter int ID_W = can_filt_pkg::NUM_BYTES * can_filt_pkg::BYTE_W
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            frm_done,
  input  logic [ID_W-1:0] frm_id,
  input  logic            frm_ide,
  input  logic            hit,
  input  logic            clr_full,
  input  logic            clr_ovr,
  output logic [ID_W-1:0] bg_id,
  output logic            bg_ide,
  output logic [ID_W-1:0] fg_id,
  output logic            fg_ide,
  output logic            full,
  output logic            ovr,
  output logic            accept_evt,
  output logic            reject_evt,
  output logic            load_evt,
  output logic            overrun_evt
);
  logic pend;
  logic busy;

  assign busy        = full && !clr_full;
  assign accept_evt  = pend && hit;
  assign reject_evt  = pend && !hit;
  assign load_evt    = accept_evt && !busy;
  assign overrun_evt = accept_evt && busy;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bg_id  <= '0;
      bg_ide <= 1'b0;
      pend   <= 1'b0;
    end else begin
      pend <= frm_done;
      if (frm_done) begin
        bg_id  <= frm_id;
        bg_ide <= frm_ide;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fg_id  <= '0;
      fg_ide <= 1'b0;
      full   <= 1'b0;
      ovr    <= 1'b0;
    end else begin
      if (clr_full) full <= 1'b0;
      if (load_evt) begin
        fg_id  <= bg_id;
        fg_ide <= bg_ide;
        full   <= 1'b1;
      end
      if (clr_ovr)     ovr <= 1'b0;
      if (overrun_evt) ovr <= 1'b1;
    end
  end
endmodule

// File: rtl/can_id_filter.sv
module can_id_filter #(
  parameter int BYTE_W    = can_filt_pkg::BYTE_W,
  parameter int NUM_BYTES = can_filt_pkg::NUM_BYTES,
  parameter int STD_BYTES = can_filt_pkg::STD_BYTES,
  localparam int ID_W     = NUM_BYTES * BYTE_W,
  localparam int AW       = $clog2(2 * NUM_BYTES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              init_req,
  input  logic              init_ack,
  input  logic              cfg_we,
  input  logic [AW-1:0]     cfg_addr,
  input  logic [BYTE_W-1:0] cfg_wdata,
  output logic [BYTE_W-1:0] cfg_rdata,
  input  logic              frm_done,
  input  logic [ID_W-1:0]   frm_id,
  input  logic              frm_ide,
  output logic [ID_W-1:0]   bg_id,
  output logic              bg_ide,
  output logic [ID_W-1:0]   rx_id,
  output logic              rx_ide,
  output logic              rx_full,
  output logic              rx_ovr,
  input  logic              rx_clr_full,
  input  logic              rx_clr_ovr
);
  logic            wr_ok;
  logic [ID_W-1:0] acc_flat;
  logic [ID_W-1:0] msk_flat;
  logic            hit;
  logic            accept_evt;
  logic            reject_evt;
  logic            load_evt;
  logic            overrun_evt;

  assign wr_ok = cfg_we && init_req && init_ack;

  can_filt_regs #(.BYTE_W(BYTE_W), .NUM_BYTES(NUM_BYTES)) regs_i (
    .clk(clk), .rst_n(rst_n), .wr_ok(wr_ok), .addr(cfg_addr),
    .wdata(cfg_wdata), .rdata(cfg_rdata),
    .acc_flat(acc_flat), .msk_flat(msk_flat)
  );

  can_filt_match #(.BYTE_W(BYTE_W), .NUM_BYTES(NUM_BYTES), .STD_BYTES(STD_BYTES)) match_i (
    .id_flat(bg_id), .ide(bg_ide), .acc_flat(acc_flat), .msk_flat(msk_flat), .hit(hit)
  );

  can_filt_rxbuf #(.ID_W(ID_W)) rxbuf_i (
    .clk(clk), .rst_n(rst_n), .frm_done(frm_done), .frm_id(frm_id), .frm_ide(frm_ide),
    .hit(hit), .clr_full(rx_clr_full), .clr_ovr(rx_clr_ovr),
    .bg_id(bg_id), .bg_ide(bg_ide), .fg_id(rx_id), .fg_ide(rx_ide),
    .full(rx_full), .ovr(rx_ovr),
    .accept_evt(accept_evt), .reject_evt(reject_evt),
    .load_evt(load_evt), .overrun_evt(overrun_evt)
  );
endmodule

// File: rtl/can_id_filter_chk.sv
module can_id_filter_chk #(
  parameter int ID_W = 32
) (
  input logic            clk,
  input logic            rst_n,
  input logic            init_req,
  input logic            init_ack,
  input logic            cfg_we,
  input logic            frm_done,
  input logic [ID_W-1:0] frm_id,
  input logic            frm_ide,
  input logic [ID_W-1:0] bg_id,
  input logic            bg_ide,
  input logic [ID_W-1:0] rx_id,
  input logic            rx_full,
  input logic            rx_ovr,
  input logic            rx_clr_full,
  input logic [ID_W-1:0] acc_flat,
  input logic [ID_W-1:0] msk_flat,
  input logic            accept_evt,
  input logic            reject_evt,
  input logic            load_evt
);
  AST_BG_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
    frm_done |=> (bg_id == $past(frm_id) && bg_ide == $past(frm_ide))); // R1
  AST_ACCEPT_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
    accept_evt |=> rx_full); // R2
  AST_REJECT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    reject_evt |=> ($stable(rx_id) && $stable(rx_ovr))); // R5
  AST_WRITE_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_we && !(init_req && init_ack)) |=> ($stable(acc_flat) && $stable(msk_flat))); // R6
  AST_FG_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_full && !rx_clr_full) |=> ($stable(rx_id) && rx_full)); // R9
  AST_OVR_NEEDS_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rx_ovr) |-> $past(rx_full)); // R9
  AST_FULL_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_clr_full && !load_evt) |=> !rx_full); // R10
endmodule

bind can_id_filter can_id_filter_chk #(.ID_W(ID_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .init_req(init_req), .init_ack(init_ack),
  .cfg_we(cfg_we), .frm_done(frm_done), .frm_id(frm_id), .frm_ide(frm_ide),
  .bg_id(bg_id), .bg_ide(bg_ide), .rx_id(rx_id), .rx_full(rx_full),
  .rx_ovr(rx_ovr), .rx_clr_full(rx_clr_full), .acc_flat(acc_flat),
  .msk_flat(msk_flat), .accept_evt(accept_evt), .reject_evt(reject_evt),
  .load_evt(load_evt)
);

// File: tb/can_id_filter_tb_top.sv
`timescale 1ns/1ps
module can_id_filter_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        init_req = 0, init_ack = 0, cfg_we = 0;
  logic [2:0]  cfg_addr = '0;
  logic [7:0]  cfg_wdata = '0;
  logic [7:0]  cfg_rdata;
  logic        frm_done = 0, frm_ide = 0;
  logic [31:0] frm_id = '0;
  logic [31:0] bg_id, rx_id;
  logic        bg_ide, rx_ide, rx_full, rx_ovr;
  logic        rx_clr_full = 0, rx_clr_ovr = 0;

  int tests = 0;
  int fails = 0;
  bit compare_on = 0;
  bit finished = 0;

  always #10 clk = ~clk; // 50 MHz

  can_id_filter dut_i (
    .clk(clk), .rst_n(rst_n), .init_req(init_req), .init_ack(init_ack),
    .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
    .frm_done(frm_done), .frm_id(frm_id), .frm_ide(frm_ide),
    .bg_id(bg_id), .bg_ide(bg_ide), .rx_id(rx_id), .rx_ide(rx_ide),
    .rx_full(rx_full), .rx_ovr(rx_ovr),
    .rx_clr_full(rx_clr_full), .rx_clr_ovr(rx_clr_ovr)
  );

  // Behavioural reference model
  byte unsigned m_acc [4];
  byte unsigned m_msk [4];
  logic [31:0]  m_bg, m_fg;
  bit           m_bgi, m_fgi, m_full, m_ovr, m_pend;

  always @(posedge clk) begin
    if (!rst_n) begin
      foreach (m_acc[i]) begin m_acc[i] = 0; m_msk[i] = 0; end
      m_bg = 0; m_fg = 0; m_bgi = 0; m_fgi = 0;
      m_full = 0; m_ovr = 0; m_pend = 0;
    end else begin
      bit ok;
      bit busy;
      ok = m_pend;
      if (m_pend) begin
        for (int k = 0; k < (m_bgi ? 4 : 2); k++)
          for (int b = 0; b < 8; b++)
            if (!m_msk[k][b] && (m_bg[8*k+b] != m_acc[k][b])) ok = 0;
      end
      busy = m_full && !rx_clr_full;
      if (rx_clr_full) m_full = 0;
      if (rx_clr_ovr)  m_ovr  = 0;
      if (ok) begin
        if (busy) m_ovr = 1;
        else begin m_fg = m_bg; m_fgi = m_bgi; m_full = 1; end
      end
      if (frm_done) begin m_bg = frm_id; m_bgi = frm_ide; end
      m_pend = frm_done;
      if (cfg_we && init_req && init_ack) begin
        if (cfg_addr < 4) m_acc[cfg_addr] = cfg_wdata;
        else              m_msk[cfg_addr - 4] = cfg_wdata;
      end
    end
  end

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // Compare every output with the model on every cycle, away from the edge
  always @(negedge clk) begin
    if (compare_on && !finished) begin
      chk("R1", "bg_id", bg_id, m_bg);
      chk("R1", "bg_ide", 32'(bg_ide), 32'(m_bgi));
      chk("R2", "rx_id", rx_id, m_fg);
      chk("R2", "rx_ide", 32'(rx_ide), 32'(m_fgi));
      chk("R10", "rx_full", 32'(rx_full), 32'(m_full));
      chk("R9", "rx_ovr", 32'(rx_ovr), 32'(m_ovr));
      chk("R7", "cfg_rdata", 32'(cfg_rdata),
          32'(cfg_addr < 4 ? m_acc[cfg_addr] : m_msk[cfg_addr - 4]));
    end
  end

  task automatic tick();
    @(posedge clk); #5;
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    cfg_we = 1; cfg_addr = a; cfg_wdata = d; tick(); cfg_we = 0;
  endtask

  task automatic rd_chk(input string req, input logic [2:0] a, input logic [7:0] exp);
    cfg_addr = a; #1;
    chk(req, "readback", 32'(cfg_rdata), 32'(exp));
  endtask

  // Frame strobe, then wait for the capture edge and the decision edge
  task automatic send(input logic [31:0] id, input logic ide);
    frm_done = 1; frm_id = id; frm_ide = ide; tick();
    frm_done = 0; tick();
  endtask

  task automatic clear_full();
    rx_clr_full = 1; tick(); rx_clr_full = 0;
  endtask

  initial begin
    #(20 * 200000);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finished = 1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (3) tick();
    rst_n = 1; tick();
    compare_on = 1;
    // R8 reset state
    for (int a = 0; a < 8; a++) rd_chk("R8", 3'(a), 8'h00);
    chk("R8", "rx_full", 32'(rx_full), 0);
    chk("R8", "rx_ovr", 32'(rx_ovr), 0);

    // R6 writes outside init mode are ignored
    init_req = 1; init_ack = 0; wr(3'd0, 8'hAA);
    rd_chk("R6", 3'd0, 8'h00);
    init_req = 0; init_ack = 1; wr(3'd5, 8'h55);
    rd_chk("R6", 3'd5, 8'h00);

    // Program in init mode
    init_req = 1; init_ack = 1;
    wr(3'd0, 8'h12); wr(3'd1, 8'h34); wr(3'd2, 8'h56); wr(3'd3, 8'h78);
    wr(3'd4, 8'h00); wr(3'd5, 8'h0F); wr(3'd6, 8'h00); wr(3'd7, 8'h01);
    init_req = 0; init_ack = 0;
    rd_chk("R7", 3'd2, 8'h56);
    rd_chk("R7", 3'd5, 8'h0F);

    // R3 exact extended match
    send(32'h78563412, 1);
    chk("R3", "exact ext full", 32'(rx_full), 1);
    chk("R3", "exact ext id", rx_id, 32'h78563412);
    clear_full();
    chk("R10", "cleared", 32'(rx_full), 0);

    // R2 masked bit differs -> accept
    send(32'h79563412, 1);
    chk("R2", "masked bit", rx_id, 32'h79563412);
    clear_full();

    // R3 unmasked bit in byte 3 differs -> reject (R5 nothing changes)
    send(32'h7A563412, 1);
    chk("R3", "ext byte3 reject", 32'(rx_full), 0);
    chk("R5", "fg kept", rx_id, 32'h79563412);
    chk("R1", "bg holds rejected", bg_id, 32'h7A563412);

    // R4 same id as standard -> bytes 2,3 ignored
    send(32'h7A563412, 0);
    chk("R4", "std accept", 32'(rx_full), 1);
    chk("R4", "std ide", 32'(rx_ide), 0);
    clear_full();

    // R4 standard with byte1 unmasked difference, and byte0 difference -> reject
    send(32'hFFFF4412, 0);
    chk("R4", "std byte1 reject", 32'(rx_full), 0);
    send(32'h00003413, 0);
    chk("R4", "std byte0 reject", 32'(rx_full), 0);
    send(32'h00003512, 0);
    chk("R2", "std masked nibble", rx_id, 32'h00003512);

    // R9 overrun while full
    send(32'h78563412, 1);
    chk("R9", "overrun set", 32'(rx_ovr), 1);
    chk("R9", "fg kept", rx_id, 32'h00003512);

    // R11 clear overrun
    rx_clr_ovr = 1; tick(); rx_clr_ovr = 0;
    chk("R11", "ovr cleared", 32'(rx_ovr), 0);

    // R10 clear in the decision cycle loads the frame
    frm_done = 1; frm_id = 32'h78563412; frm_ide = 1; tick();
    frm_done = 0; rx_clr_full = 1; tick(); rx_clr_full = 0;
    chk("R10", "same-cycle clear load", rx_id, 32'h78563412);
    chk("R10", "no overrun", 32'(rx_ovr), 0);

    // R11 clear and new overrun in the same cycle: set wins
    frm_done = 1; frm_id = 32'h78563412; tick();
    frm_done = 0; rx_clr_ovr = 1; tick(); rx_clr_ovr = 0;
    chk("R11", "set wins", 32'(rx_ovr), 1);

    // Back-to-back frames: R1 capture each, R5 rejected overwritten
    clear_full();
    frm_done = 1; frm_id = 32'h11111111; frm_ide = 1; tick();
    frm_id = 32'h78563412; tick();
    frm_done = 0; tick();
    chk("R1", "back-to-back bg", bg_id, 32'h78563412);
    chk("R5", "b2b accept second", rx_id, 32'h78563412);
    tick();

    finished = 1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule